// File: doc/BRIEF.md
# Sequential Booth Radix-2 Multiplier

This block multiplies two signed two's complement operands of `W` bits each. It returns a signed product of `2W` bits. The operands need no sign handling before or after the multiply. The block spends one clock per multiplier bit. In each step it looks at the low bit of a rotating copy of the multiplier and at a one-bit history of the bit examined before it. From that pair it subtracts the multiplicand from the upper half of the accumulator, adds it, or leaves the accumulator alone. It then shifts the whole accumulator pair right by one position, arithmetically.

The upper half of the accumulator is one bit wider than `W`. This extra bit keeps the sign correct when the most negative multiplicand is subtracted. A one-cycle `start` pulse while idle captures both operands. `busy` stays high for the `W` steps. `done` then pulses for one cycle, and `product` keeps its value until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: `start` sampled high while `busy` is 0 captures `x_in` and `y_in`, and `busy` is 1 from the next cycle on.
- R3: For every pair of `W`-bit two's complement operands, `product` equals their signed product as a `2W`-bit two's complement value.
- R4: Exactly `W` steps run. `done` is 1, and `busy` is 0, in the cycle that follows the `W+1`-th rising edge counted from the edge that sampled `start`.
- R5: `done` is high for exactly one cycle per multiplication and is never high while `busy` is high.
- R6: `start` sampled while `busy` is 1 has no effect: the running product and its timing are unchanged.
- R7: After `done`, `product` holds its value until the next accepted `start`.
- R8: Multiplying the most negative operand by itself gives the positive value 2^(2W-2), with the top bit of `product` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (honoured only when idle) |
| x_in | input | W | Multiplicand, two's complement |
| y_in | input | W | Multiplier, two's complement |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse after the last step |
| product | output | 2W | Signed product |

## Verification
The edge that samples `start` loads the operands. Each of the next `W` edges performs one step, and the last of those edges raises `done`. The bench therefore drives `start` at a falling edge and waits for the loading edge. It confirms `busy` at the next falling edge, then counts exactly `W` more falling edges before it checks `done`, `busy` and `product`. One falling edge later it checks that `done` has dropped and that `product` still holds.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   y_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W) + 1;

  logic [W:0]    acc;
  logic [W-1:0]  lo;
  logic [W-1:0]  mcand;
  logic [W-1:0]  yrot;
  logic          yprev;
  logic [CW-1:0] cnt;
  logic [W:0]    mext;
  logic [W:0]    sum;
  logic          last;

  assign mext = {mcand[W-1], mcand};
  assign last = (cnt == CW'(W - 1));

  always_comb begin
    case ({yrot[0], yprev})
      2'b10:   sum = acc - mext;
      2'b01:   sum = acc + mext;
      default: sum = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      lo    <= '0;
      mcand <= '0;
      yrot  <= '0;
      yprev <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc   <= '0;
          lo    <= '0;
          mcand <= x_in;
          yrot  <= y_in;
          yprev <= 1'b0;
          cnt   <= '0;
          busy  <= 1'b1;
        end
      end else begin
        acc   <= {sum[W], sum[W:1]};
        lo    <= {sum[0], lo[W-1:1]};
        yrot  <= {yrot[0], yrot[W-1:1]};
        yprev <= yrot[0];
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = {acc[W-1:0], lo};

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> busy);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;
  localparam int W = 4;
  localparam int PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   x_in = '0;
  logic [W-1:0]   y_in = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad = 0;

  booth_seq_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .busy(busy), .done(done), .product(product)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input int a, input int b);
    int sa, sb, p;
    sa = (a >= (1 << (W-1))) ? a - (1 << W) : a;
    sb = (b >= (1 << (W-1))) ? b - (1 << W) : b;
    p = sa * sb;
    return p[2*W-1:0];
  endfunction

  // spurious: pulse start during busy with other operands (R6)
  task automatic run_mul(input int a, input int b, input bit spurious);
    logic [2*W-1:0] expv;
    expv = ref_mul(a, b);
    @(negedge clk);
    x_in = W'(a);
    y_in = W'(b);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", longint'(busy), 1);
    for (int i = 0; i < W; i++) begin
      if (spurious && i == 1) begin
        x_in = ~W'(a);
        y_in = W'(b) + 1'b1;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (i < W - 1) begin
        @(negedge clk);
        if (i == W - 2) start = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    start = 1'b0;
    check("R4 done after W steps", longint'(done), 1);
    check("R4 busy low at done", longint'(busy), 0);
    check(spurious ? "R6 product unaffected" : "R3 product", longint'(product), longint'(expv));
    @(negedge clk);
    check("R5 done one cycle", longint'(done), 0);
    check("R7 product held", longint'(product), longint'(expv));
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 3);
    check("R1 busy reset", longint'(busy), 0);
    check("R1 done reset", longint'(done), 0);
    check("R1 product reset", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_mul(a, b, 1'b0);
    run_mul(1 << (W-1), 1 << (W-1), 1'b0);
    check("R8 min*min positive", longint'(product), longint'(1) << (2*W-2));
    run_mul(5, 3, 1'b1);
    run_mul(1 << (W-1), 7, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 product idle hold", longint'(product), longint'(ref_mul(1 << (W-1), 7)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule